// File: doc/BRIEF.md
# ALU Operation Decoder with Register-Jump Flag

This purely combinational decoder sits between the main instruction control and the ALU of a single-cycle datapath. It takes a 2-bit operation class chosen by the main control and the 6-bit function field of the current instruction. It returns a 3-bit ALU operation select. It also returns a separate flag that steers the next-PC multiplexer to a register value when the instruction is a register-indirect jump.

The main control uses the class to pick between three uses of the ALU. Memory and immediate instructions always need an add. Branch comparison always needs a subtract. Register-format instructions take their operation from the function field. Only add, subtract, AND and OR are recognised. Every other function code falls back to a defined add, so the select never carries an unknown value.

The block holds no state, so it has no state machine, clock or reset. It consists of a function-field decoder and a class selector under the top module.

Top module: `alu_op_decoder`

## Requirements
- R1: With operation class 2'b00 the select is add (3'b010) and the jump flag is low, whatever the function field holds (for instance 6'b001000).
- R2: With operation class 2'b01 the select is subtract (3'b110) and the jump flag is low, whatever the function field holds.
- R3: With operation class 2'b10 and function field 6'b100000 the select is add (3'b010).
- R4: With operation class 2'b10 and function field 6'b100010 the select is subtract (3'b110).
- R5: With operation class 2'b10 and function field 6'b100100 the select is AND (3'b000).
- R6: With operation class 2'b10 and function field 6'b100101 the select is OR (3'b001).
- R7: With operation class 2'b10 and function field 6'b001000 the jump flag is high and the select is add (3'b010).
- R8: With operation class 2'b10 and any function field not named in R3 to R7, the select is add (3'b010) and the jump flag is low.
- R9: The unused operation class 2'b11 behaves like class 2'b00: the select is add and the jump flag is low for every function field.
- R10: The jump flag is high only for the pair class 2'b10 with function field 6'b001000, and the select is always one of 3'b000, 3'b001, 3'b010 or 3'b110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main control |
| funct | input | 6 | Function field of the instruction |
| alu_sel | output | 3 | ALU operation select |
| jr_sel | output | 1 | High for a register-indirect jump; selects the next-PC source |

## Verification
The bench builds the decoder with its only configuration: a 6-bit function field and a 2-bit class. This makes the whole input space of 256 pairs small enough to sweep exhaustively. Each pair is compared against a table derived from the requirements. The sweep therefore reaches every unlisted function code in the default path, including the register-jump code under the other classes, where the flag must stay low.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

    localparam int FUNCT_W = 6;
    localparam int CLASS_W = 2;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110
    } alu_sel_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM   = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_RTYPE = 2'b10,
        CLS_RSVD  = 2'b11
    } op_class_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_JR  = 6'b001000;

endpackage

// File: rtl/rfunct_decode.sv
module rfunct_decode
    import alu_dec_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct,
    output alu_sel_e           fn_sel,
    output logic               fn_jr
);

    always_comb begin
        fn_sel = ALU_ADD;
        fn_jr  = 1'b0;
        unique case (funct)
            FN_ADD:  fn_sel = ALU_ADD;
            FN_SUB:  fn_sel = ALU_SUB;
            FN_AND:  fn_sel = ALU_AND;
            FN_OR:   fn_sel = ALU_OR;
            FN_JR:   fn_jr  = 1'b1;
            default: begin
                fn_sel = ALU_ADD;
                fn_jr  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/class_select.sv
module class_select
    import alu_dec_pkg::*;
(
    input  op_class_e op_cls,
    input  alu_sel_e  fn_sel,
    input  logic      fn_jr,
    output alu_sel_e  out_sel,
    output logic      out_jr
);

    always_comb begin
        out_sel = ALU_ADD;
        out_jr  = 1'b0;
        unique case (op_cls)
            CLS_MEM:   out_sel = ALU_ADD;
            CLS_CMP:   out_sel = ALU_SUB;
            CLS_RTYPE: begin
                out_sel = fn_sel;
                out_jr  = fn_jr;
            end
            CLS_RSVD:  out_sel = ALU_ADD;
            default:   out_sel = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_dec_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNCT_W-1:0] funct,
    output logic [SEL_W-1:0]   alu_sel,
    output logic               jr_sel
);

    alu_sel_e  fn_sel_w;
    logic      fn_jr_w;
    alu_sel_e  out_sel_w;
    op_class_e cls_w;

    assign cls_w = op_class_e'(op_class);

    rfunct_decode u_fn (
        .funct  (funct),
        .fn_sel (fn_sel_w),
        .fn_jr  (fn_jr_w)
    );

    class_select u_cls (
        .op_cls  (cls_w),
        .fn_sel  (fn_sel_w),
        .fn_jr   (fn_jr_w),
        .out_sel (out_sel_w),
        .out_jr  (jr_sel)
    );

    assign alu_sel = out_sel_w;

endmodule

// File: rtl/alu_op_decoder_chk.sv
module alu_op_decoder_chk (
    input logic [1:0] op_class,
    input logic [5:0] funct,
    input logic [2:0] alu_sel,
    input logic       jr_sel
);

    always_comb begin
        // R1
        mem_add_chk: assert (op_class != 2'b00 || (alu_sel == 3'b010 && !jr_sel))
            else $error("class 00 mismatch");
        // R2
        cmp_sub_chk: assert (op_class != 2'b01 || (alu_sel == 3'b110 && !jr_sel))
            else $error("class 01 mismatch");
        // R9
        rsvd_add_chk: assert (op_class != 2'b11 || (alu_sel == 3'b010 && !jr_sel))
            else $error("class 11 mismatch");
        // R7
        jr_set_chk: assert (!(op_class == 2'b10 && funct == 6'b001000) || (jr_sel && alu_sel == 3'b010))
            else $error("jump pair not flagged");
        // R10
        jr_only_chk: assert (!jr_sel || (op_class == 2'b10 && funct == 6'b001000))
            else $error("jump flag on wrong pair");
        // R10
        sel_legal_chk: assert (alu_sel == 3'b000 || alu_sel == 3'b001 || alu_sel == 3'b010 || alu_sel == 3'b110)
            else $error("illegal select");
        // R5
        rt_and_chk: assert (!(op_class == 2'b10 && funct == 6'b100100) || alu_sel == 3'b000)
            else $error("AND decode");
        // R6
        rt_or_chk: assert (!(op_class == 2'b10 && funct == 6'b100101) || alu_sel == 3'b001)
            else $error("OR decode");
    end

endmodule

bind alu_op_decoder alu_op_decoder_chk u_chk (
    .op_class (op_class),
    .funct    (funct),
    .alu_sel  (alu_sel),
    .jr_sel   (jr_sel)
);

// File: tb/alu_op_decoder_tb_top.sv
module alu_op_decoder_tb_top;

    logic       clk;
    logic       rst_n;
    logic [1:0] op_class;
    logic [5:0] funct;
    logic [2:0] alu_sel;
    logic       jr_sel;

    int n_checks;
    int n_fail;
    bit done;

    alu_op_decoder dut_i (
        .op_class (op_class),
        .funct    (funct),
        .alu_sel  (alu_sel),
        .jr_sel   (jr_sel)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // expected values from R1..R10
    function automatic logic [3:0] expect_of(input logic [1:0] c, input logic [5:0] f);
        logic [2:0] s;
        logic j;
        s = 3'b010;
        j = 1'b0;
        if (c == 2'b01) s = 3'b110;
        else if (c == 2'b10) begin
            if (f == 6'b100010) s = 3'b110;
            else if (f == 6'b100100) s = 3'b000;
            else if (f == 6'b100101) s = 3'b001;
            else if (f == 6'b001000) j = 1'b1;
        end
        return {j, s};
    endfunction

    task automatic apply_and_check(input logic [1:0] c, input logic [5:0] f, input string req);
        logic [3:0] e;
        @(negedge clk);
        op_class = c;
        funct    = f;
        #1;
        e = expect_of(c, f);
        n_checks++;
        if ({jr_sel, alu_sel} !== e) begin
            n_fail++;
            $display("FAIL %s class=%b funct=%b actual jr=%b sel=%b expected jr=%b sel=%b",
                     req, c, f, jr_sel, alu_sel, e[3], e[2:0]);
        end
    endtask

    task automatic t_reset_state;
        // R1: idle inputs during reset give add
        apply_and_check(2'b00, 6'b000000, "R1");
    endtask

    task automatic t_fixed_classes;
        apply_and_check(2'b00, 6'b001000, "R1");
        apply_and_check(2'b00, 6'b100010, "R1");
        apply_and_check(2'b01, 6'b100100, "R2");
        apply_and_check(2'b01, 6'b001000, "R2");
        apply_and_check(2'b11, 6'b001000, "R9");
        apply_and_check(2'b11, 6'b100101, "R9");
    endtask

    task automatic t_rtype_ops;
        apply_and_check(2'b10, 6'b100000, "R3");
        apply_and_check(2'b10, 6'b100010, "R4");
        apply_and_check(2'b10, 6'b100100, "R5");
        apply_and_check(2'b10, 6'b100101, "R6");
    endtask

    task automatic t_jump;
        apply_and_check(2'b10, 6'b001000, "R7");
        apply_and_check(2'b10, 6'b001001, "R10");
    endtask

    task automatic t_defaults;
        apply_and_check(2'b10, 6'b000000, "R8");
        apply_and_check(2'b10, 6'b101010, "R8");
        apply_and_check(2'b10, 6'b111111, "R8");
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 64; f++)
                apply_and_check(2'(c), 6'(f), "R10");
    endtask

    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        op_class = 2'b00;
        funct    = 6'b000000;
        t_reset_state();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_fixed_classes();
        t_rtype_ops();
        t_jump();
        t_defaults();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule